// File: doc/BRIEF.md
# Transmit Descriptor-Chain Channel

This block is one transmit DMA channel. It walks a linked list of buffer descriptors held in a small local memory and sends each descriptor's buffer out as a byte stream over a valid/ready interface. Each descriptor takes four 32-bit words at a 16-byte aligned address:

| Word | Contents |
|------|----------|
| +0 | next-descriptor pointer |
| +4 | buffer pointer |
| +8 | buffer length |
| +12 | mode/status word |

Software builds descriptors and buffers through a memory port. It writes a head pointer to start the channel and a control bit to enable it. The engine hands each descriptor back by rewriting its mode word.

Software can link a new descriptor onto a finished queue and restart the channel by writing the head pointer again. A teardown command stops the channel cleanly. The engine marks the descriptor it was working on as torn down and posts a sentinel value in the completion register. The channel then stays frozen until software echoes that sentinel back.

Top module: `txdc_channel`

## Requirements
- R1: After a head pointer is accepted, the engine reads the descriptor at that address. It streams the descriptor's buffer, then follows the next pointer (word +0) until it reaches a descriptor whose next pointer is zero. A zero pointer is never a descriptor address.
- R2: Bytes leave in ascending byte-address order from the buffer pointer (word +4), for the number of bytes given in word +8. Within a memory word, the byte at the lowest address is bits 7:0. The buffer pointer may be unaligned. While tx_valid is high and tx_ready is low, tx_data holds its value.
- R3: tx_last is high only on the final byte of a descriptor whose mode bit 30 (end of packet) is set. While that descriptor streams, tx_port_en shows mode bit 20 and tx_port shows mode bits 18:16.
- R4: No descriptor is fetched and no byte is sent while the control enable (register 0, bit 0) is 0. A head pointer written in that state is held until enable becomes 1.
- R5: When a descriptor finishes, its mode word (word +12) is rewritten with ownership bit 29 cleared. End-of-queue bit 28 is set only when the next pointer is zero. All other bits are unchanged. No other descriptor word is written.
- R6: A head pointer write accepted after end-of-queue restarts the channel at the new address.
- R7: A head pointer write (register 1) is ignored while the channel is working on a descriptor. A zero head pointer is also ignored.
- R8: A fetched descriptor whose ownership bit 29 is clear is not sent and its mode word is not changed. Instead host_err rises and stays high until reset.
- R9: Writing the channel number (parameter, default 2) to register 2 requests teardown; any other value is ignored. The current descriptor is abandoned mid-stream, and its mode word gets bit 27 set and bit 29 cleared. The completion value (cp_value) then becomes 0xFFFFFFFC.
- R10: Between a teardown request and a software write of 0xFFFFFFFC to register 3, head pointer writes are ignored. After that write, the channel is idle and accepts a head pointer again.
- R11: A software write to register 3 loads cp_value. After reset, cp_value is 0, host_err is 0 and tx_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 head, 2 teardown, 3 completion |
| reg_wdata | input | 32 | Register write data |
| mem_we | input | 1 | Descriptor/buffer memory write strobe |
| mem_addr | input | AW | Memory word index |
| mem_wdata | input | 32 | Memory write data |
| mem_rdata | output | 32 | Memory read data at mem_addr |
| tx_valid | output | 1 | Byte valid |
| tx_ready | input | 1 | Byte accepted by the sink |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Last byte of a packet |
| tx_port_en | output | 1 | Directed-output request for this descriptor |
| tx_port | output | 3 | Target port number |
| cp_value | output | 32 | Completion register value |
| host_err | output | 1 | Sticky host-error flag |

## Verification
The assertions check four behaviours on every cycle:
- the held byte stays stable across a stall;
- the host-error flag stays set once raised;
- descriptor writeback touches only mode words and never overlaps a sent byte;
- an engine-side teardown always leaves the sentinel in the completion register.

Only the bench scenarios can show the rest:
- bytes follow the chain in order, including unaligned buffers and the directed-port sideband;
- the final mode words carry the correct end-of-queue and teardown bits;
- head writes made while busy or during teardown are really dropped, which shows up as descriptors that keep their ownership bit and produce no bytes.

// File: rtl/txdc_pkg.sv
`timescale 1ns/1ps
package txdc_pkg;

    // Mode/status word bit positions
    localparam int MODE_SOP     = 31;
    localparam int MODE_EOP     = 30;
    localparam int MODE_OWN     = 29;
    localparam int MODE_EOQ     = 28;
    localparam int MODE_TDC     = 27;
    localparam int MODE_DIR     = 20;
    localparam int MODE_PORT_HI = 18;
    localparam int MODE_PORT_LO = 16;

    localparam logic [31:0] TD_SENTINEL = 32'hFFFF_FFFC;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_HEAD  = 2'd1,
        RA_TDOWN = 2'd2,
        RA_DONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MODE,
        ST_NEXT,
        ST_BUF,
        ST_LEN,
        ST_STREAM,
        ST_DONE,
        ST_CPW,
        ST_TDWAIT
    } eng_state_e;

    // Mode word as handed back to software
    function automatic logic [31:0] retire_mode(input logic [31:0] m,
                                                input logic tail,
                                                input logic torn);
        logic [31:0] r;
        r = m;
        r[MODE_OWN] = 1'b0;
        if (tail) r[MODE_EOQ] = 1'b1;
        if (torn) r[MODE_TDC] = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] pick_byte(input logic [31:0] w,
                                             input logic [1:0] lane);
        case (lane)
            2'd0:    return w[7:0];
            2'd1:    return w[15:8];
            2'd2:    return w[23:16];
            default: return w[31:24];
        endcase
    endfunction

endpackage

// File: rtl/txdc_desc_mem.sv
`timescale 1ns/1ps
module txdc_desc_mem #(
    parameter int WORDS = 64,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          sw_we,
    input  logic [AW-1:0] sw_addr,
    input  logic [31:0]   sw_wdata,
    output logic [31:0]   sw_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [31:0]   eng_wdata,
    output logic [31:0]   eng_rdata
);
    logic [31:0] store [WORDS];

    // engine writeback is applied last and wins a same-word collision
    always_ff @(posedge clk) begin
        if (sw_we)  store[sw_addr]  <= sw_wdata;
        if (eng_we) store[eng_addr] <= eng_wdata;
    end

    assign sw_rdata  = store[sw_addr];
    assign eng_rdata = store[eng_addr];
endmodule

// File: rtl/txdc_regs.sv
`timescale 1ns/1ps
module txdc_regs
    import txdc_pkg::*;
#(
    parameter logic [31:0] CHAN_ID = 32'd2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        cp_set,
    output logic        en,
    output logic [31:0] cp_value,
    output logic        head_wr,
    output logic        td_req,
    output logic        td_release
);
    assign head_wr    = reg_wr && (reg_addr == RA_HEAD);
    assign td_req     = reg_wr && (reg_addr == RA_TDOWN) && (reg_wdata == CHAN_ID);
    assign td_release = reg_wr && (reg_addr == RA_DONE)  && (reg_wdata == TD_SENTINEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            en       <= 1'b0;
            cp_value <= '0;
        end else begin
            if (reg_wr && reg_addr == RA_CTRL) en <= reg_wdata[0];
            if (reg_wr && reg_addr == RA_DONE) cp_value <= reg_wdata;
            else if (cp_set)                   cp_value <= TD_SENTINEL;
        end
    end
endmodule

// File: rtl/txdc_engine.sv
`timescale 1ns/1ps
module txdc_engine
    import txdc_pkg::*;
#(
    parameter  int AW  = 6,
    localparam int BW  = AW + 2,
    localparam int DIW = AW - 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          head_wr,
    input  logic [31:0]   head_ptr,
    input  logic          td_req,
    input  logic          td_release,
    output logic          eng_we,
    output logic [AW-1:0] eng_addr,
    output logic [31:0]   eng_wdata,
    input  logic [31:0]   eng_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          tx_port_en,
    output logic [2:0]    tx_port,
    input  logic          tx_ready,
    output logic          cp_set,
    output logic          host_err
);
    eng_state_e     st_q;
    logic [DIW-1:0] cur_q, head_q, nxt_q;
    logic           head_pend_q, nxt_nz_q, td_q, err_q;
    logic [31:0]    mode_q;
    logic [BW-1:0]  buf_q;
    logic [15:0]    len_q, idx_q;

    logic          starting, head_take, last_beat, streaming;
    logic [BW-1:0] byte_ptr;

    assign starting  = (st_q == ST_IDLE) && !td_q && head_pend_q && en;
    assign head_take = head_wr && (st_q == ST_IDLE) && !td_q
                       && !(head_pend_q && en) && (|head_ptr);
    assign byte_ptr  = buf_q + idx_q[BW-1:0];
    assign last_beat = (idx_q == len_q - 16'd1);
    assign streaming = (st_q == ST_STREAM) && !td_q && (len_q != 16'd0);

    always_comb begin
        case (st_q)
            ST_NEXT:   eng_addr = {cur_q, 2'b00};
            ST_BUF:    eng_addr = {cur_q, 2'b01};
            ST_LEN:    eng_addr = {cur_q, 2'b10};
            ST_STREAM: eng_addr = byte_ptr[BW-1:2];
            default:   eng_addr = {cur_q, 2'b11};
        endcase
    end

    assign eng_we     = (st_q == ST_DONE);
    assign eng_wdata  = retire_mode(mode_q, !nxt_nz_q, td_q);
    assign tx_valid   = streaming;
    assign tx_data    = pick_byte(eng_rdata, byte_ptr[1:0]);
    assign tx_last    = streaming && last_beat && mode_q[MODE_EOP];
    assign tx_port_en = streaming && mode_q[MODE_DIR];
    assign tx_port    = streaming ? mode_q[MODE_PORT_HI:MODE_PORT_LO] : 3'd0;
    assign cp_set     = (st_q == ST_CPW);
    assign host_err   = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            cur_q       <= '0;
            head_q      <= '0;
            nxt_q       <= '0;
            head_pend_q <= 1'b0;
            nxt_nz_q    <= 1'b0;
            td_q        <= 1'b0;
            err_q       <= 1'b0;
            mode_q      <= '0;
            buf_q       <= '0;
            len_q       <= '0;
            idx_q       <= '0;
        end else begin
            if (td_req && !td_q) td_q <= 1'b1;
            case (st_q)
                ST_IDLE: begin
                    if (td_q) begin
                        st_q <= ST_CPW;
                    end else if (starting) begin
                        cur_q       <= head_q;
                        head_pend_q <= 1'b0;
                        st_q        <= ST_MODE;
                    end else if (head_take) begin
                        head_q      <= head_ptr[BW-1:4];
                        head_pend_q <= 1'b1;
                    end
                end
                ST_MODE: begin
                    if (!eng_rdata[MODE_OWN]) begin
                        err_q <= 1'b1;
                        st_q  <= td_q ? ST_CPW : ST_IDLE;
                    end else begin
                        mode_q <= eng_rdata;
                        st_q   <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    nxt_q    <= eng_rdata[BW-1:4];
                    nxt_nz_q <= |eng_rdata;
                    st_q     <= ST_BUF;
                end
                ST_BUF: begin
                    buf_q <= eng_rdata[BW-1:0];
                    st_q  <= ST_LEN;
                end
                ST_LEN: begin
                    len_q <= eng_rdata[15:0];
                    idx_q <= '0;
                    st_q  <= ST_STREAM;
                end
                ST_STREAM: begin
                    if (td_q || len_q == 16'd0) begin
                        st_q <= ST_DONE;
                    end else if (tx_ready) begin
                        idx_q <= idx_q + 16'd1;
                        if (last_beat) st_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (td_q) begin
                        st_q <= ST_CPW;
                    end else begin
                        if (nxt_nz_q) begin
                            head_q      <= nxt_q;
                            head_pend_q <= 1'b1;
                        end
                        st_q <= ST_IDLE;
                    end
                end
                ST_CPW: begin
                    head_pend_q <= 1'b0;
                    st_q        <= ST_TDWAIT;
                end
                ST_TDWAIT: begin
                    if (td_release) begin
                        td_q <= 1'b0;
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txdc_channel.sv
`timescale 1ns/1ps
module txdc_channel
    import txdc_pkg::*;
#(
    parameter  int          MEM_WORDS = 64,
    parameter  logic [31:0] CHAN_ID   = 32'd2,
    localparam int          AW        = $clog2(MEM_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_addr,
    input  logic [31:0]   mem_wdata,
    output logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          tx_port_en,
    output logic [2:0]    tx_port,
    output logic [31:0]   cp_value,
    output logic          host_err
);
    logic          en, head_wr, td_req, td_release, cp_set;
    logic          eng_we;
    logic [AW-1:0] eng_addr;
    logic [31:0]   eng_wdata, eng_rdata;

    txdc_regs #(.CHAN_ID(CHAN_ID)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cp_set(cp_set), .en(en), .cp_value(cp_value),
        .head_wr(head_wr), .td_req(td_req), .td_release(td_release)
    );

    txdc_desc_mem #(.WORDS(MEM_WORDS), .AW(AW)) u_mem (
        .clk(clk), .sw_we(mem_we), .sw_addr(mem_addr), .sw_wdata(mem_wdata),
        .sw_rdata(mem_rdata), .eng_we(eng_we), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
    );

    txdc_engine #(.AW(AW)) u_eng (
        .clk(clk), .rst(rst), .en(en), .head_wr(head_wr), .head_ptr(reg_wdata),
        .td_req(td_req), .td_release(td_release), .eng_we(eng_we),
        .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_port_en(tx_port_en), .tx_port(tx_port), .tx_ready(tx_ready),
        .cp_set(cp_set), .host_err(host_err)
    );
endmodule

// File: rtl/txdc_checker.sv
`timescale 1ns/1ps
module txdc_checker (
    input logic        clk,
    input logic        rst,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        mem_we,
    input logic        host_err,
    input logic        eng_we,
    input logic [1:0]  eng_sel,
    input logic        cp_set,
    input logic        td_req,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] cp_value
);
    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !td_req && !mem_we) |=> (tx_valid && $stable(tx_data)));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        host_err |=> host_err);

    assert_wb_mode_only_R5: assert property (@(posedge clk) disable iff (rst)
        eng_we |-> (eng_sel == 2'b11));

    assert_wb_no_beat_R5: assert property (@(posedge clk) disable iff (rst)
        eng_we |-> !tx_valid);

    assert_sentinel_post_R9: assert property (@(posedge clk) disable iff (rst)
        (cp_set && !(reg_wr && reg_addr == 2'd3)) |=> (cp_value == 32'hFFFF_FFFC));
endmodule

bind txdc_channel txdc_checker u_chk (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .mem_we(mem_we), .host_err(host_err),
    .eng_we(eng_we), .eng_sel(eng_addr[1:0]), .cp_set(cp_set),
    .td_req(td_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .cp_value(cp_value)
);

// File: tb/txdc_channel_test.sv
`timescale 1ns/1ps
module txdc_channel_test;
    localparam int          MW   = 64;
    localparam int          AW   = 6;
    localparam logic [31:0] CHID = 32'd2;
    localparam logic [31:0] SOP = 32'h8000_0000, EOP = 32'h4000_0000,
                            OWN = 32'h2000_0000, EOQ = 32'h1000_0000,
                            TDC = 32'h0800_0000, DIR = 32'h0010_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          mem_we = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [31:0]   mem_wdata = '0;
    logic [31:0]   mem_rdata;
    logic          tx_valid, tx_last, tx_port_en, host_err;
    logic          tx_ready = 1'b1;
    logic [7:0]    tx_data;
    logic [2:0]    tx_port;
    logic [31:0]   cp_value;

    int   checks = 0;
    int   fails  = 0;
    logic finished = 1'b0;
    logic [12:0] exp_q[$];

    always #2.5 clk = ~clk;

    txdc_channel #(.MEM_WORDS(MW), .CHAN_ID(CHID)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .tx_port_en(tx_port_en), .tx_port(tx_port), .cp_value(cp_value),
        .host_err(host_err)
    );

    function automatic logic [7:0] pat(input int b);
        return 8'(b) ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic mem_write(input int baddr, input logic [31:0] d);
        @(posedge clk); #1;
        mem_we = 1'b1; mem_addr = AW'(baddr >> 2); mem_wdata = d;
        @(posedge clk); #1;
        mem_we = 1'b0;
    endtask

    task automatic mem_read(input int baddr, output logic [31:0] d);
        @(posedge clk); #1;
        mem_addr = AW'(baddr >> 2);
        #1;
        d = mem_rdata;
    endtask

    task automatic write_desc(input int a, input int nxt, input int bufp,
                              input int len, input logic [31:0] mode);
        mem_write(a,      32'(nxt));
        mem_write(a + 4,  32'(bufp));
        mem_write(a + 8,  32'(len));
        mem_write(a + 12, mode);
    endtask

    task automatic check_word(input int a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        mem_read(a, v);
        check(v == exp, req, v, exp);
    endtask

    // driver side of the scoreboard
    task automatic push_bytes(input int bufp, input int len, input bit eop,
                              input bit pen, input logic [2:0] port);
        for (int i = 0; i < len; i++)
            exp_q.push_back({pen, port, (eop && i == len - 1), pat(bufp + i)});
    endtask

    // monitor side: a beat is taken at the next rising edge
    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            logic [12:0] item;
            logic [12:0] e;
            item = {tx_port_en, tx_port, tx_last, tx_data};
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 R7 R10 unexpected byte", 32'(item), 32'h0);
            end else begin
                e = exp_q.pop_front();
                check(item == e, "R1 R2 R3 stream byte", 32'(item), 32'(e));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        // R11 reset state
        check(tx_valid == 1'b0, "R11 reset tx_valid", 32'(tx_valid), 32'h0);
        check(host_err == 1'b0, "R11 reset host_err", 32'(host_err), 32'h0);
        check(cp_value == 32'h0, "R11 reset cp_value", cp_value, 32'h0);

        // buffer area 0x80..0xFF holds pat(byte address)
        for (int w = 32; w < 64; w++)
            mem_write(w * 4, {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});

        // R1 R3 R4: two-descriptor chain, held off by enable
        write_desc(32'h10, 32'h20, 32'h80, 5, SOP | OWN | 32'd5);
        write_desc(32'h20, 0, 32'h85, 3, EOP | OWN | DIR | (32'd5 << 16) | 32'd3);
        reg_write(2'd1, 32'h10);
        tick(20);
        check(tx_valid == 1'b0, "R4 no byte while disabled", 32'(tx_valid), 32'h0);
        check_word(32'h1C, SOP | OWN | 32'd5, "R4 descriptor untouched while disabled");
        push_bytes(32'h80, 5, 1'b0, 1'b0, 3'd0);
        push_bytes(32'h85, 3, 1'b1, 1'b1, 3'd5);
        reg_write(2'd0, 32'h1);
        tick(40);
        check(exp_q.size() == 0, "R1 chain fully streamed", 32'(exp_q.size()), 32'h0);
        check_word(32'h1C, SOP | 32'd5, "R5 mid-chain mode word");
        check_word(32'h2C, EOP | DIR | (32'd5 << 16) | 32'd3 | EOQ, "R5 tail mode word");

        // R6 late append
        write_desc(32'h30, 0, 32'h90, 4, SOP | EOP | OWN | 32'd4);
        mem_write(32'h20, 32'h30);
        push_bytes(32'h90, 4, 1'b1, 1'b0, 3'd0);
        reg_write(2'd1, 32'h30);
        tick(30);
        check(exp_q.size() == 0, "R6 restart after end of queue", 32'(exp_q.size()), 32'h0);
        check_word(32'h3C, SOP | EOP | EOQ | 32'd4, "R6 appended descriptor retired");

        // R7 head write while busy, R2 stall hold
        write_desc(32'h40, 0, 32'hA0, 20, SOP | EOP | OWN | 32'd20);
        write_desc(32'h50, 0, 32'hC0, 2, SOP | EOP | OWN | 32'd2);
        tx_ready = 1'b0;
        reg_write(2'd1, 32'h40);
        tick(10);
        check(tx_valid == 1'b1, "R2 valid during stall", 32'(tx_valid), 32'h1);
        check(tx_data == pat(32'hA0), "R2 first byte", 32'(tx_data), 32'(pat(32'hA0)));
        reg_write(2'd1, 32'h0);
        reg_write(2'd1, 32'h50);
        tick(3);
        check(tx_data == pat(32'hA0), "R2 byte held in stall", 32'(tx_data), 32'(pat(32'hA0)));
        push_bytes(32'hA0, 20, 1'b1, 1'b0, 3'd0);
        tx_ready = 1'b1;
        tick(60);
        check(exp_q.size() == 0, "R7 long descriptor streamed", 32'(exp_q.size()), 32'h0);
        check_word(32'h5C, SOP | EOP | OWN | 32'd2, "R7 busy head write ignored");

        // R9 R10 teardown
        write_desc(32'h60, 0, 32'hD0, 20, SOP | EOP | OWN | 32'd20);
        tx_ready = 1'b0;
        reg_write(2'd1, 32'h60);
        tick(8);
        reg_write(2'd2, 32'h1);
        tick(5);
        check(tx_valid == 1'b1, "R9 wrong channel number ignored", 32'(tx_valid), 32'h1);
        reg_write(2'd2, CHID);
        tick(10);
        check(tx_valid == 1'b0, "R9 stream abandoned", 32'(tx_valid), 32'h0);
        check(cp_value == 32'hFFFF_FFFC, "R9 sentinel posted", cp_value, 32'hFFFF_FFFC);
        check_word(32'h6C, SOP | EOP | EOQ | TDC | 32'd20, "R9 torn descriptor mode");
        reg_write(2'd1, 32'h50);
        tx_ready = 1'b1;
        tick(10);
        reg_write(2'd3, 32'hFFFF_FFFC);
        tick(20);
        check_word(32'h5C, SOP | EOP | OWN | 32'd2, "R10 head write during teardown ignored");
        push_bytes(32'hC0, 2, 1'b1, 1'b0, 3'd0);
        reg_write(2'd1, 32'h50);
        tick(20);
        check(exp_q.size() == 0, "R10 channel usable after release", 32'(exp_q.size()), 32'h0);
        check_word(32'h5C, SOP | EOP | EOQ | 32'd2, "R10 descriptor retired");

        // R8 descriptor not owned by hardware
        write_desc(32'h70, 0, 32'hE0, 2, SOP | EOP | 32'd2);
        reg_write(2'd1, 32'h70);
        tick(10);
        check(host_err == 1'b1, "R8 host error raised", 32'(host_err), 32'h1);
        check_word(32'h7C, SOP | EOP | 32'd2, "R8 mode word untouched");
        tick(5);
        check(host_err == 1'b1, "R8 host error sticky", 32'(host_err), 32'h1);

        // R11 completion register write
        reg_write(2'd3, 32'h20);
        tick(1);
        check(cp_value == 32'h20, "R11 completion readback", cp_value, 32'h20);
        check(exp_q.size() == 0, "R1 scoreboard drained", 32'(exp_q.size()), 32'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule